// File: doc/BRIEF.md
# Device Wake and Access Handshake

This block holds the general-purpose control word through which a host brings a device core out of low power before it touches internal resources. The host writes two control bits: init-done, which allows the core to run, and access-request, which holds the core awake. A five-state power sequencer acts on them. It reports clock-ready only after a wake latency has passed. It announces an imminent sleep through a going-to-sleep flag before it powers the core down. It also encodes the present power-save type in a three-bit field.

The core may start to sleep only when no access request is pending and an idle input from the core is asserted. A request that arrives while the sleep entry runs is remembered and wakes the core as soon as the entry completes. A software-reset input clears both host bits and sends the core straight to low power. A hardware RF-kill pin is mirrored in the control word, and each change of that pin produces a one-cycle event pulse for the interrupt logic. Clock gating and analog power-up are modelled only as cycle counts.

Top module: `dev_wake_ctrl`

## Requirements
- R1: After reset the control word reads 0x0100_0000: clock-ready (bit 0), init-done (bit 2), access-request (bit 3), going-to-sleep (bit 4) and the RF-kill mirror (bit 27) are 0, and the power-save type (bits 26:24) is 001.
- R2: A write stores only bit 2 (init-done) and bit 3 (access-request); every other bit of the written word has no effect on the control word.
- R3: Clock-ready stays 0 while init-done is 0, even with access-request set; starting from the off state, it rises exactly WAKE_LAT+1 cycles after the edge that accepts a write setting init-done.
- R4: While init-done and access-request are both 1, an awake core stays awake (clock-ready held at 1) whatever the idle input does.
- R5: When the core is awake with access-request 0 and idle 1, on the next edge going-to-sleep rises and clock-ready falls; going-to-sleep stays 1 for exactly SLEEP_LAT cycles, after which the core is asleep with type 001 and both flags at 0.
- R6: An access request seen at any time during the sleep entry, even one withdrawn before the entry ends, makes the core wake again when the entry completes; it never reaches the asleep state.
- R7: From the asleep state, a write setting access-request makes clock-ready rise exactly WAKE_LAT+1 cycles after the accepting edge.
- R8: A software-reset pulse clears init-done and access-request and puts the core in the off state on the same edge. It takes priority over a write in the same cycle.
- R9: Clearing init-done while the core is awake drops clock-ready on the second edge after the write and returns the core to the off state (type 001).
- R10: The power-save type is 011 (error) whenever access-request is 1 and init-done is 0. Otherwise it is 010 while awake with the radio-off input high, 001 in the off and asleep states, and 000 in the waking, awake and going-to-sleep states.
- R11: Bit 27 follows the RF-kill pin one edge late. On that same edge, each change of the pin produces a one-cycle pulse on rfkill_evt; a steady pin produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_reset | input | 1 | Software reset command, one-cycle pulse |
| wr_en | input | 1 | Host write strobe for the control word |
| wr_data | input | 32 | Host write data; only bits 2 and 3 are stored |
| core_idle | input | 1 | Core reports it has nothing to do |
| radio_off | input | 1 | Radio section powered down while core is awake |
| rfkill_pin | input | 1 | Hardware RF-kill switch level |
| ctrl_rdata | output | 32 | Control word as read by the host |
| clk_ready | output | 1 | Core clock running, internal access allowed |
| going_sleep | output | 1 | Sleep entry in progress |
| rfkill_evt | output | 1 | One-cycle pulse on any RF-kill pin change |

## Verification
The bench measures the exact wake and sleep-entry latencies in cycles. A counter that is off by one shifts clock-ready by a cycle and would let the host touch the core before it is up. It sends a short access pulse during the sleep entry, so a design that looks only at the current request level falls asleep and strands the host. It checks that access-request without init-done never wakes the core and reports the error type, and that a software reset beats a write in the same cycle. It sweeps RF-kill toggles at several spacings to catch a pulse that is missing, stretched or fired by a steady pin.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    typedef enum logic [2:0] {
        PW_OFF     = 3'd0,
        PW_WAKING  = 3'd1,
        PW_AWAKE   = 3'd2,
        PW_GTS     = 3'd3,
        PW_ASLEEP  = 3'd4
    } pw_state_e;

    // Control word bit positions decoded by the host
    localparam int BIT_CLK_RDY = 0;
    localparam int BIT_INIT    = 2;
    localparam int BIT_REQ     = 3;
    localparam int BIT_GTS     = 4;
    localparam int BIT_TYPE_LO = 24;
    localparam int BIT_RFKILL  = 27;

    // Power-save type codes
    localparam logic [2:0] PS_NONE  = 3'b000;
    localparam logic [2:0] PS_MAC   = 3'b001;
    localparam logic [2:0] PS_RADIO = 3'b010;
    localparam logic [2:0] PS_ERROR = 3'b011;

endpackage

// File: rtl/dwc_rf_edge.sv
module dwc_rf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic evt
);

    typedef struct packed {
        logic lvl;
        logic evt;
    } rf_t;

    rf_t r_q, r_d;

    always_comb begin
        r_d.lvl = pin;
        r_d.evt = pin ^ r_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign level = r_q.lvl;
    assign evt   = r_q.evt;

    // An event pulse only accompanies a change of the mirrored level
    assert_evt_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (level != $past(level)));

endmodule

// File: rtl/dwc_wake_fsm.sv
module dwc_wake_fsm
    import dwc_pkg::*;
#(
    parameter int WAKE_LAT  = 8,
    parameter int SLEEP_LAT = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_reset,
    input  logic      init_done,
    input  logic      acc_req,
    input  logic      core_idle,
    output pw_state_e state,
    output logic      clk_ready,
    output logic      going_sleep
);

    localparam int MAX_LAT = (WAKE_LAT > SLEEP_LAT) ? WAKE_LAT : SLEEP_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [CNT_W-1:0] WAKE_END  = CNT_W'(WAKE_LAT - 1);
    localparam logic [CNT_W-1:0] SLEEP_END = CNT_W'(SLEEP_LAT - 1);

    typedef struct packed {
        pw_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: PW_OFF, cnt: '0, pend: 1'b0};

    fsm_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        case (f_q.st)
            PW_OFF: begin
                if (init_done) begin
                    f_d.st  = PW_WAKING;
                    f_d.cnt = '0;
                end
            end
            PW_WAKING: begin
                if (!init_done) begin
                    f_d.st = PW_OFF;
                end else if (f_q.cnt == WAKE_END) begin
                    f_d.st  = PW_AWAKE;
                    f_d.cnt = '0;
                end else begin
                    f_d.cnt = f_q.cnt + CNT_W'(1);
                end
            end
            PW_AWAKE: begin
                if (!init_done) begin
                    f_d.st = PW_OFF;
                end else if (!acc_req && core_idle) begin
                    f_d.st   = PW_GTS;
                    f_d.cnt  = '0;
                    f_d.pend = 1'b0;
                end
            end
            PW_GTS: begin
                f_d.pend = f_q.pend | acc_req;
                if (!init_done) begin
                    f_d.st   = PW_OFF;
                    f_d.pend = 1'b0;
                end else if (f_q.cnt == SLEEP_END) begin
                    f_d.st   = (f_q.pend || acc_req) ? PW_WAKING : PW_ASLEEP;
                    f_d.cnt  = '0;
                    f_d.pend = 1'b0;
                end else begin
                    f_d.cnt = f_q.cnt + CNT_W'(1);
                end
            end
            PW_ASLEEP: begin
                if (!init_done) begin
                    f_d.st = PW_OFF;
                end else if (acc_req) begin
                    f_d.st  = PW_WAKING;
                    f_d.cnt = '0;
                end
            end
            default: f_d = FSM_RST;
        endcase
        if (sw_reset) f_d = FSM_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= FSM_RST;
        else        f_q <= f_d;
    end

    assign state       = f_q.st;
    assign clk_ready   = (f_q.st == PW_AWAKE);
    assign going_sleep = (f_q.st == PW_GTS);

    // A request seen during sleep entry never lets the core fall asleep
    assert_req_in_gts_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (going_sleep && acc_req && init_done && !sw_reset) |=> (state != PW_ASLEEP));

    // The wake counter never runs past its end value while waking
    assert_wake_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_WAKING) |-> (f_q.cnt <= WAKE_END));

endmodule

// File: rtl/dev_wake_ctrl.sv
module dev_wake_ctrl
    import dwc_pkg::*;
#(
    parameter int WAKE_LAT  = 8,
    parameter int SLEEP_LAT = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              core_idle,
    input  logic              radio_off,
    input  logic              rfkill_pin,
    output logic [DATA_W-1:0] ctrl_rdata,
    output logic              clk_ready,
    output logic              going_sleep,
    output logic              rfkill_evt
);

    typedef struct packed {
        logic init;
        logic req;
    } host_t;

    host_t h_q, h_d;

    pw_state_e  state;
    logic       rf_level;
    logic [2:0] ps_type;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DATA_W-1:BIT_REQ+1], wr_data[BIT_INIT-1:0]};

    always_comb begin
        h_d = h_q;
        if (wr_en) begin
            h_d.init = wr_data[BIT_INIT];
            h_d.req  = wr_data[BIT_REQ];
        end
        if (sw_reset) h_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    dwc_wake_fsm #(
        .WAKE_LAT  (WAKE_LAT),
        .SLEEP_LAT (SLEEP_LAT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset    (sw_reset),
        .init_done   (h_q.init),
        .acc_req     (h_q.req),
        .core_idle   (core_idle),
        .state       (state),
        .clk_ready   (clk_ready),
        .going_sleep (going_sleep)
    );

    dwc_rf_edge u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (rfkill_pin),
        .level (rf_level),
        .evt   (rfkill_evt)
    );

    always_comb begin
        if (h_q.req && !h_q.init) begin
            ps_type = PS_ERROR;
        end else begin
            case (state)
                PW_OFF, PW_ASLEEP: ps_type = PS_MAC;
                PW_AWAKE:          ps_type = radio_off ? PS_RADIO : PS_NONE;
                default:           ps_type = PS_NONE;
            endcase
        end
    end

    always_comb begin
        ctrl_rdata                           = '0;
        ctrl_rdata[BIT_CLK_RDY]              = clk_ready;
        ctrl_rdata[BIT_INIT]                 = h_q.init;
        ctrl_rdata[BIT_REQ]                  = h_q.req;
        ctrl_rdata[BIT_GTS]                  = going_sleep;
        ctrl_rdata[BIT_TYPE_LO+2:BIT_TYPE_LO] = ps_type;
        ctrl_rdata[BIT_RFKILL]               = rf_level;
    end

    // Without init-done the core cannot be ready on the following edge
    assert_ready_needs_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !h_q.init |=> !clk_ready);

    // A held request keeps an awake core awake
    assert_hold_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && h_q.init && h_q.req && !sw_reset) |=> clk_ready);

    // Sleep entry starts only from awake with no request pending
    assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(going_sleep) |-> ($past(clk_ready) && !$past(h_q.req)));

    // Software reset wipes the host bits on its edge
    assert_swrst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!h_q.init && !h_q.req && !clk_ready));

endmodule

// File: tb/dev_wake_ctrl_bench.sv
module dev_wake_ctrl_bench;

    localparam int WL = 3;
    localparam int SL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        core_idle = 1'b0;
    logic        radio_off = 1'b0;
    logic        rfkill_pin = 1'b0;
    logic [31:0] ctrl_rdata;
    logic        clk_ready;
    logic        going_sleep;
    logic        rfkill_evt;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dev_wake_ctrl #(.WAKE_LAT(WL), .SLEEP_LAT(SL)) u_dev_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wr_en(wr_en),
        .wr_data(wr_data), .core_idle(core_idle), .radio_off(radio_off),
        .rfkill_pin(rfkill_pin), .ctrl_rdata(ctrl_rdata), .clk_ready(clk_ready),
        .going_sleep(going_sleep), .rfkill_evt(rfkill_evt)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!clk_ready && n < 60) begin
            cyc(1);
            n++;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        bit saw_sleep;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset word
        chk(ctrl_rdata == 32'h0100_0000, "R1 reset word", ctrl_rdata, 32'h0100_0000);

        // R2 write with only non-storable bits set
        wr(32'hFFFF_FFF3);
        chk(ctrl_rdata == 32'h0100_0000, "R2 read-only bits ignored", ctrl_rdata, 32'h0100_0000);
        cyc(5);
        chk(!clk_ready, "R3 no ready without init", {31'd0, clk_ready}, 0);

        // R3 wake latency from off
        wr(32'h0000_0004);
        wait_ready(n);
        chk(n == WL + 1, "R3 wake latency", n, WL + 1);

        // R4 hold awake with request while idle
        wr(32'h0000_000C);
        core_idle = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (!clk_ready)
                chk(1'b0, "R4 dropped while requested", {31'd0, clk_ready}, 1);
        end
        chk(clk_ready, "R4 still awake", {31'd0, clk_ready}, 1);
        chk(ctrl_rdata[26:24] == 3'b000, "R10 awake type", ctrl_rdata[26:24], 0);
        radio_off = 1'b1;
        #1;
        chk(ctrl_rdata[26:24] == 3'b010, "R10 radio-off type", ctrl_rdata[26:24], 2);
        radio_off = 1'b0;

        // R5 sleep entry
        wr(32'h0000_0004);
        cyc(1);
        chk(going_sleep && !clk_ready, "R5 flag raised, ready low",
            {30'd0, going_sleep, clk_ready}, 32'h2);
        chk(ctrl_rdata[26:24] == 3'b000, "R10 sleep-entry type", ctrl_rdata[26:24], 0);
        n = 0;
        while (going_sleep && n < 60) begin
            n++;
            cyc(1);
        end
        chk(n == SL, "R5 sleep entry length", n, SL);
        chk(ctrl_rdata == 32'h0100_0004, "R5 asleep word", ctrl_rdata, 32'h0100_0004);
        cyc(10);
        chk(ctrl_rdata == 32'h0100_0004, "R5 stays asleep", ctrl_rdata, 32'h0100_0004);

        // R7 wake from asleep
        wr(32'h0000_000C);
        wait_ready(n);
        chk(n == WL + 1, "R7 wake latency from asleep", n, WL + 1);

        // R6 short request pulse during sleep entry
        core_idle = 1'b0;
        wr(32'h0000_0004);
        core_idle = 1'b1;
        cyc(1);
        chk(going_sleep, "R6 entered sleep entry", {31'd0, going_sleep}, 1);
        core_idle = 1'b0;
        wr(32'h0000_000C);
        wr(32'h0000_0004);
        saw_sleep = 1'b0;
        n = 0;
        while (!clk_ready && n < 60) begin
            if (ctrl_rdata[26:24] == 3'b001) saw_sleep = 1'b1;
            cyc(1);
            n++;
        end
        chk(clk_ready, "R6 woke after sleep entry", {31'd0, clk_ready}, 1);
        chk(!saw_sleep, "R6 never asleep", {31'd0, saw_sleep}, 0);

        // R9 clearing init while awake
        wr(32'h0000_0000);
        cyc(1);
        chk(!clk_ready && ctrl_rdata[26:24] == 3'b001, "R9 back to off",
            ctrl_rdata, 32'h0100_0000);

        // R8 software reset beats a simultaneous write
        wr(32'h0000_0004);
        wait_ready(n);
        chk(clk_ready, "R8 precondition awake", {31'd0, clk_ready}, 1);
        sw_reset = 1'b1;
        wr_en = 1'b1;
        wr_data = 32'h0000_000C;
        cyc(1);
        sw_reset = 1'b0;
        wr_en = 1'b0;
        chk(ctrl_rdata == 32'h0100_0000, "R8 reset word", ctrl_rdata, 32'h0100_0000);

        // R10 error type, R3 request alone never wakes
        wr(32'h0000_0008);
        chk(ctrl_rdata[26:24] == 3'b011, "R10 error type", ctrl_rdata[26:24], 3);
        cyc(10);
        chk(!clk_ready, "R3 request without init", {31'd0, clk_ready}, 0);
        wr(32'h0000_0000);
        chk(ctrl_rdata[26:24] == 3'b001, "R10 off type", ctrl_rdata[26:24], 1);

        // R11 RF-kill toggles at several spacings
        chk(!rfkill_evt, "R11 no event on steady pin", {31'd0, rfkill_evt}, 0);
        for (int gap = 1; gap <= 4; gap++) begin
            for (int t = 0; t < 2; t++) begin
                rfkill_pin = ~rfkill_pin;
                cyc(1);
                chk(rfkill_evt && ctrl_rdata[27] == rfkill_pin, "R11 event and mirror",
                    {30'd0, rfkill_evt, ctrl_rdata[27]}, {30'd0, 1'b1, rfkill_pin});
                for (int k = 0; k < gap; k++) begin
                    cyc(1);
                    chk(!rfkill_evt, "R11 single-cycle pulse", {31'd0, rfkill_evt}, 0);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule